// File: doc/BRIEF.md
# Image Sensor Row Sequencer

This block generates the control waveforms that a CMOS image sensor needs at the start of each row. It steps through a fixed order: advance the row pointers, precharge the columns, connect the row to the columns, sample the pixel signal, reset the pixels, and sample the reset level for double sampling. In rolling-shutter mode it then adds a second pixel reset on the row that the trailing pointer addresses. For the first row of a frame, it sends sync pulses to the row pointers, with a fixed set-up interval before the row clock edge that samples them.

The phase lengths come from timing inputs given in clock cycles. The set-up interval is a parameter in nanoseconds, which the block converts to cycles. A request is accepted only while the block is idle. Mode, reset-black and first-row flags are captured when a request is accepted. The timing inputs must stay stable while a row is running. All pins are plain control levels, with no handshake.

Top module: `rowseq_top`

## Requirements
- R1: A `row_start` high at a clock edge while idle starts a row, and the first phase begins in the next cycle. A `row_start` during a running row has no effect: that row keeps its length and no second row follows.
- R2: The first phase after set-up drives `row_clk_l` and `row_clk_r` high together for `t_rowclk` cycles.
- R3: When `frame_first` is set, `row_sync_l` and `row_sync_r` are high for SETUP_NS/CLK_NS cycles (rounded up) before the row clocks rise, and they stay high while the clocks are high. They are never high in rows started without `frame_first`.
- R4: After the row clock phase, `prech` is high for `t_prech` cycles, and `col_sync` is high in the first cycle of that phase only.
- R5: `prech` and `row_sel` are never high in the same cycle. At least one cycle with both low separates them.
- R6: After a one-cycle gap, `row_sel` is high for `t_select` cycles with both sample-and-hold controls tracking (0). `samp_sig` then switches to hold (1) and remains 1 until the row ends.
- R7: While `samp_sig` holds and `row_sel` stays high, `pix_rst` is high for `t_reset` cycles. Next, `samp_rst` switches to hold for the rest of the row while `row_sel` stays high for `t_hold` cycles. A one-cycle gap follows.
- R8: With `black_ref` set, `pix_rst` is also high during the whole precharge phase. Without it, `pix_rst` stays low during precharge.
- R9: In rolling mode (`roll_mode`=1), a final phase of `t_reset` cycles drives `pix_rst` high with `rst_src_r`=1 and `rst_src_l`=0. In every other cycle the two selects are complementary, with `rst_src_l`=1.
- R10: In full-frame mode (`roll_mode`=0), `rst_src_l` and `rst_src_r` are both 1 in every cycle of the row.
- R11: A timing input of 0 is treated as 1 cycle.
- R12: `row_done` is high for exactly one cycle, the cycle after the last phase. In that cycle all outputs are at idle levels: `rst_src_l`=1 and every other output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_start | input | 1 | Request to run one row |
| frame_first | input | 1 | The requested row is the first of a frame |
| roll_mode | input | 1 | 1 = rolling shutter, 0 = full frame |
| black_ref | input | 1 | Also reset pixels during precharge |
| t_rowclk | input | CNT_W | Row clock high time, cycles |
| t_prech | input | CNT_W | Precharge time, cycles |
| t_select | input | CNT_W | Signal settle time with row selected, cycles |
| t_reset | input | CNT_W | Pixel reset pulse width, cycles |
| t_hold | input | CNT_W | Reset-level settle time, cycles |
| row_clk_l | output | 1 | Leading row pointer clock |
| row_clk_r | output | 1 | Trailing row pointer clock |
| row_sync_l | output | 1 | Leading pointer sync to first row |
| row_sync_r | output | 1 | Trailing pointer sync to first row |
| col_sync | output | 1 | Column pointer sync |
| prech | output | 1 | Column precharge |
| row_sel | output | 1 | Connect row to columns |
| samp_sig | output | 1 | Signal sample-and-hold, 1 = hold |
| samp_rst | output | 1 | Reset-level sample-and-hold, 1 = hold |
| pix_rst | output | 1 | Pixel reset |
| rst_src_l | output | 1 | Reset line driven by leading pointer |
| rst_src_r | output | 1 | Reset line driven by trailing pointer |
| row_done | output | 1 | One-cycle end-of-row strobe |

## Verification
The assertions assume that the timing inputs do not change while a row is running. They also assume that `frame_first` is used only as a flag captured with the request, so a sync pulse always has its full set-up interval ahead of the clock edge. The stimulus changes timing and mode inputs only while the block is idle. It sweeps every combination of mode, reset-black and first-row with phase lengths of one and two cycles, plus an all-zero timing case. It also drives extra requests in the middle of rows with the first-row flag inverted, so that a wrongly accepted request would show up as extra sync or clock activity.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_SETUP, PH_CLK, PH_PREC, PH_GAP1,
    PH_SIG, PH_RST, PH_HOLD, PH_GAP2, PH_TRAIL
  } phase_t;
endpackage

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SU_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             first_in,
  input  logic             roll_in,
  input  logic             black_in,
  input  logic [CNT_W-1:0] len_clk,
  input  logic [CNT_W-1:0] len_prec,
  input  logic [CNT_W-1:0] len_sig,
  input  logic [CNT_W-1:0] len_rst,
  input  logic [CNT_W-1:0] len_hold,
  output phase_t           phase,
  output logic             head,
  output logic             first_q,
  output logic             roll_q,
  output logic             black_q,
  output logic             done
);
  localparam int SU_W = $clog2(SU_CYC + 1);
  localparam int CW = (SU_W > CNT_W) ? SU_W : CNT_W;

  logic [CW-1:0] cnt;
  phase_t nxt;

  function automatic logic [CW-1:0] span(input phase_t ph);
    logic [CNT_W-1:0] v;
    case (ph)
      PH_SETUP: return CW'(SU_CYC);
      PH_CLK:   v = len_clk;
      PH_PREC:  v = len_prec;
      PH_SIG:   v = len_sig;
      PH_RST,
      PH_TRAIL: v = len_rst;
      PH_HOLD:  v = len_hold;
      default:  v = '0;
    endcase
    return (v == '0) ? CW'(1) : CW'(v);
  endfunction

  always_comb begin
    case (phase)
      PH_SETUP: nxt = PH_CLK;
      PH_CLK:   nxt = PH_PREC;
      PH_PREC:  nxt = PH_GAP1;
      PH_GAP1:  nxt = PH_SIG;
      PH_SIG:   nxt = PH_RST;
      PH_RST:   nxt = PH_HOLD;
      PH_HOLD:  nxt = PH_GAP2;
      PH_GAP2:  nxt = roll_q ? PH_TRAIL : PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      head    <= 1'b0;
      first_q <= 1'b0;
      roll_q  <= 1'b0;
      black_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      head <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          first_q <= first_in;
          roll_q  <= roll_in;
          black_q <= black_in;
          phase   <= first_in ? PH_SETUP : PH_CLK;
          cnt     <= span(first_in ? PH_SETUP : PH_CLK) - CW'(1);
          head    <= 1'b1;
        end
      end else if (cnt == '0) begin
        phase <= nxt;
        cnt   <= span(nxt) - CW'(1);
        head  <= (nxt != PH_IDLE);
        done  <= (nxt == PH_IDLE);
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_in_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> phase == PH_IDLE);
  p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_SETUP && start) |=> phase != PH_SETUP);
endmodule

// File: rtl/rowseq_drive.sv
module rowseq_drive
  import rowseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  input  logic   head,
  input  logic   first_q,
  input  logic   roll_q,
  input  logic   black_q,
  output logic   clk_l,
  output logic   clk_r,
  output logic   sync_l,
  output logic   sync_r,
  output logic   csync,
  output logic   prec,
  output logic   sel,
  output logic   hold_sig,
  output logic   hold_rst,
  output logic   prst,
  output logic   src_l,
  output logic   src_r
);
  logic busy;
  logic sync_on;

  assign busy    = (phase != PH_IDLE);
  assign sync_on = first_q && (phase == PH_SETUP || phase == PH_CLK);

  always_comb begin
    clk_l    = (phase == PH_CLK);
    clk_r    = clk_l;
    sync_l   = sync_on;
    sync_r   = sync_on;
    prec     = (phase == PH_PREC);
    csync    = prec && head;
    sel      = (phase == PH_SIG || phase == PH_RST || phase == PH_HOLD);
    hold_sig = (phase == PH_RST || phase == PH_HOLD || phase == PH_GAP2 || phase == PH_TRAIL);
    hold_rst = (phase == PH_HOLD || phase == PH_GAP2 || phase == PH_TRAIL);
    prst     = (phase == PH_RST) || (phase == PH_TRAIL) || (prec && black_q);
    if (!busy) begin
      src_l = 1'b1;
      src_r = 1'b0;
    end else if (roll_q) begin
      src_l = (phase != PH_TRAIL);
      src_r = (phase == PH_TRAIL);
    end else begin
      src_l = 1'b1;
      src_r = 1'b1;
    end
  end

  p_prec_sel_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(prec && sel));
  p_prec_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prec) |-> !sel);
  p_sync_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_l) && sync_l) |-> $past(sync_l));
  p_csync_in_prec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csync |-> prec);
  p_hold_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |-> hold_sig);
  p_src_compl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && roll_q) |-> (src_l != src_r));
endmodule

// File: rtl/rowseq_top.sv
module rowseq_top
  import rowseq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CLK_NS = 10,
  parameter int SETUP_NS = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic             frame_first,
  input  logic             roll_mode,
  input  logic             black_ref,
  input  logic [CNT_W-1:0] t_rowclk,
  input  logic [CNT_W-1:0] t_prech,
  input  logic [CNT_W-1:0] t_select,
  input  logic [CNT_W-1:0] t_reset,
  input  logic [CNT_W-1:0] t_hold,
  output logic             row_clk_l,
  output logic             row_clk_r,
  output logic             row_sync_l,
  output logic             row_sync_r,
  output logic             col_sync,
  output logic             prech,
  output logic             row_sel,
  output logic             samp_sig,
  output logic             samp_rst,
  output logic             pix_rst,
  output logic             rst_src_l,
  output logic             rst_src_r,
  output logic             row_done
);
  localparam int SU_CYC = (SETUP_NS + CLK_NS - 1) / CLK_NS;

  phase_t phase;
  logic   head, first_q, roll_q, black_q;

  rowseq_ctrl #(.CNT_W(CNT_W), .SU_CYC(SU_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(row_start), .first_in(frame_first),
    .roll_in(roll_mode), .black_in(black_ref),
    .len_clk(t_rowclk), .len_prec(t_prech), .len_sig(t_select),
    .len_rst(t_reset), .len_hold(t_hold),
    .phase(phase), .head(head), .first_q(first_q), .roll_q(roll_q),
    .black_q(black_q), .done(row_done)
  );

  rowseq_drive u_drive (
    .clk(clk), .rst_n(rst_n), .phase(phase), .head(head), .first_q(first_q),
    .roll_q(roll_q), .black_q(black_q),
    .clk_l(row_clk_l), .clk_r(row_clk_r), .sync_l(row_sync_l), .sync_r(row_sync_r),
    .csync(col_sync), .prec(prech), .sel(row_sel), .hold_sig(samp_sig),
    .hold_rst(samp_rst), .prst(pix_rst), .src_l(rst_src_l), .src_r(rst_src_r)
  );

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> (!prech && !row_sel && !pix_rst && !row_clk_l && !samp_sig && rst_src_l && !rst_src_r));
endmodule

// File: tb/sim_rowseq_top.sv
module sim_rowseq_top;
  localparam int W = 8;
  localparam int SU = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_start = 1'b0, frame_first = 1'b0, roll_mode = 1'b0, black_ref = 1'b0;
  logic [W-1:0] t_rowclk = '0, t_prech = '0, t_select = '0, t_reset = '0, t_hold = '0;
  logic row_clk_l, row_clk_r, row_sync_l, row_sync_r, col_sync, prech, row_sel;
  logic samp_sig, samp_rst, pix_rst, rst_src_l, rst_src_r, row_done;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rowseq_top #(.CNT_W(W), .CLK_NS(10), .SETUP_NS(200)) u0 (.*);

  wire [12:0] obs = {row_clk_l, row_clk_r, row_sync_l, row_sync_r, col_sync, prech,
                     row_sel, samp_sig, samp_rst, pix_rst, rst_src_l, rst_src_r, row_done};

  localparam logic [12:0] IDLE_V = 13'b0000000000100;

  task automatic check(input bit ok, input string tag, input logic [12:0] act, input logic [12:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic int cl(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // expected output vector for cycle i (1 = first cycle after accepted start)
  function automatic logic [12:0] model(input int i, input bit f, input bit ro, input bit bk,
      input int c, input int p, input int s, input int r, input int h, output string tag);
    int b0, b1, b2, b3, b4, b5, b6, b7, b8;
    logic ck, sy, cs, pc, se, hs, hr, pr, sl, sr, dn;
    b0 = f ? SU : 0; b1 = b0 + c; b2 = b1 + p; b3 = b2 + 1; b4 = b3 + s;
    b5 = b4 + r; b6 = b5 + h; b7 = b6 + 1; b8 = b7 + (ro ? r : 0);
    {ck, sy, cs, pc, se, hs, hr, pr, dn} = '0;
    sl = 1'b1; sr = ro ? 1'b0 : 1'b1;
    if (i <= b0) begin sy = 1; tag = "R3 setup"; end
    else if (i <= b1) begin ck = 1; sy = f; tag = "R2 rowclk"; end
    else if (i <= b2) begin pc = 1; cs = (i == b1 + 1); pr = bk; tag = "R4/R8 precharge"; end
    else if (i <= b3) begin tag = "R5 gap"; end
    else if (i <= b4) begin se = 1; tag = "R6 select"; end
    else if (i <= b5) begin se = 1; hs = 1; pr = 1; tag = "R7 reset"; end
    else if (i <= b6) begin se = 1; hs = 1; hr = 1; tag = "R7 hold"; end
    else if (i <= b7) begin hs = 1; hr = 1; tag = "R10 gap2"; end
    else if (i <= b8) begin hs = 1; hr = 1; pr = 1; sl = 0; sr = 1; tag = "R9 trailing reset"; end
    else begin sl = 1; sr = 0; dn = (i == b8 + 1); tag = "R12 done"; end
    return {ck, ck, sy, sy, cs, pc, se, hs, hr, pr, sl, sr, dn};
  endfunction

  task automatic run_row(input bit f, input bit ro, input bit bk,
      input int c, input int p, input int s, input int r, input int h, input bit zero);
    int len;
    string tag;
    logic [12:0] e;
    @(negedge clk);
    frame_first = f; roll_mode = ro; black_ref = bk;
    t_rowclk = zero ? 0 : W'(c); t_prech = zero ? 0 : W'(p); t_select = zero ? 0 : W'(s);
    t_reset = zero ? 0 : W'(r); t_hold = zero ? 0 : W'(h);
    row_start = 1'b1;
    @(negedge clk);
    row_start = 1'b0;
    len = (f ? SU : 0) + cl(c) + cl(p) + 1 + cl(s) + cl(r) + cl(h) + 1 + (ro ? cl(r) : 0);
    for (int i = 1; i <= len + 3; i++) begin
      e = model(i, f, ro, bk, cl(c), cl(p), cl(s), cl(r), cl(h), tag);
      if (zero) tag = {tag, " R11"};
      if (i > len + 1) tag = "R1 no second row";
      check(obs === e, tag, obs, e);
      // R1: a request mid-row with the first flag inverted must be ignored
      row_start = (i == 2 || i == len - 1);
      frame_first = (i == 2 || i == len - 1) ? ~f : f;
      @(negedge clk);
    end
    row_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(obs === IDLE_V, "R12 reset state", obs, IDLE_V);
    rst_n = 1'b1;
    @(negedge clk);
    check(obs === IDLE_V, "R12 idle after reset", obs, IDLE_V);
    for (int m = 0; m < 8; m++)
      for (int t = 0; t < 32; t++)
        run_row(m[2], m[1], m[0], 1 + t[0], 1 + t[1], 1 + t[2], 1 + t[3], 1 + t[4], 1'b0);
    run_row(1'b1, 1'b1, 1'b1, 0, 0, 0, 0, 0, 1'b1);
    run_row(1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b1);
    run_row(1'b0, 1'b1, 1'b0, 5, 3, 4, 6, 2, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule